// File: doc/BRIEF.md
# Timestamped Sample Buffer with Interrupt-Driven Host Drain

The block gathers acquisition samples into a local store and hands them to a host in whole batches. Each accepted sample is tagged with its channel number and with the value of an internal time-of-day counter. The counter advances on every clock cycle in which a tick-enable input is high, so a slower time base can be obtained by pulsing that input.

When the last free slot of the store is written, the block raises an interrupt request. It then waits for the host to acknowledge. After the acknowledge it presents the stored words on a valid/ready output port, oldest first, until the store is empty. It then goes back to collecting samples. Samples that arrive while a batch is waiting or draining are discarded, and a sticky overrun flag records that this happened. The host works at its own pace: the block starts each exchange, and the host decides when to acknowledge and when to accept each word.

Top module: `acq_xfer_ctrl`

## Requirements
- R1: While collecting, every cycle with `smp_valid` high stores one entry. `irq_req` stays low until DEPTH entries (default 64) have been stored.
- R2: An output word holds the timestamp in bits [31:16], the channel in bits [15:12] and the sample in bits [11:0]. The timestamp is the counter value in the cycle the sample was written.
- R3: The time-of-day counter resets to 0. It adds one in each cycle that `tick_en` is high, holds otherwise, and wraps modulo 2^16.
- R4: `irq_req` rises in the cycle after the write that fills the store. It stays high until `irq_ack` is seen, and `out_valid` is low while it is high.
- R5: In the cycle after `irq_ack` is sampled high with `irq_req` high, `irq_req` is low and `out_valid` is high.
- R6: Words leave in the order they were written. A word advances only when `out_valid` and `out_ready` are both high, and `out_word` holds steady while `out_valid` is high and `out_ready` is low.
- R7: A sample offered while a request is pending or a drain is running is not stored. `overrun` is set and stays set until reset.
- R8: After the host accepts the last word, `out_valid` drops and the block collects again from an empty store. A further DEPTH samples are needed before the next request.
- R9: `irq_ack` has no effect while no request is pending.
- R10: Out of reset, `irq_req`, `out_valid` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_en | input | 1 | Advances the time-of-day counter |
| smp_valid | input | 1 | A sample is offered this cycle |
| smp_data | input | 12 | Sample value |
| smp_chan | input | 4 | Channel number of the sample |
| irq_req | output | 1 | Interrupt request: a full batch is ready |
| irq_ack | input | 1 | Host acknowledge of the request |
| out_valid | output | 1 | Output word is valid |
| out_ready | input | 1 | Host accepts the output word |
| out_word | output | 32 | Stored entry {timestamp, channel, sample} |
| overrun | output | 1 | Sticky flag for discarded samples |

## Verification
The first batch is written with gaps between samples, and the tick-enable input is held high. The second batch is written after an idle stretch long enough to wrap the timestamp, with tick-enable toggling between samples. This separates a counter that follows tick-enable and wraps from one that counts free or saturates. The host drains the first batch with a stalling ready pattern and the second with ready held high, which shows whether the read pointer advances only on a handshake and whether order is kept under stalls. Samples offered during a pending request, and a stray acknowledge while collecting, show that the store and the handshake ignore input outside their phase.

// File: rtl/acq_xfer_pkg.sv
package acq_xfer_pkg;
   typedef enum logic [1:0] {
      ST_COLLECT = 2'd0,
      ST_REQUEST = 2'd1,
      ST_DRAIN   = 2'd2
   } xfer_state_e;
endpackage

// File: rtl/acq_tod_counter.sv
module acq_tod_counter #(
   parameter int TS_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_en,
   output logic [TS_W-1:0] ts_now
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ts_now <= '0;
      else if (tick_en) ts_now <= ts_now + 1'b1;
   end
endmodule

// File: rtl/acq_sample_store.sv
module acq_sample_store #(
   parameter int WORD_W = 32,
   parameter int DEPTH  = 64,
   localparam int AW    = $clog2(DEPTH)
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [AW-1:0]     wr_addr,
   input  logic [WORD_W-1:0] wr_word,
   input  logic [AW-1:0]     rd_addr,
   output logic [WORD_W-1:0] rd_word
);
   logic [WORD_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem[wr_addr] <= wr_word;
   end

   assign rd_word = mem[rd_addr];
endmodule

// File: rtl/acq_xfer_seq.sv
module acq_xfer_seq
   import acq_xfer_pkg::*;
#(
   parameter int DEPTH = 64,
   localparam int AW   = $clog2(DEPTH)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_valid,
   input  logic          irq_ack,
   input  logic          out_ready,
   output logic          wr_en,
   output logic [AW-1:0] wr_addr,
   output logic [AW-1:0] rd_addr,
   output logic          irq_req,
   output logic          out_valid,
   output logic          overrun
);
   localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

   xfer_state_e   state;
   logic [AW-1:0] fill_cnt;
   logic [AW-1:0] rd_cnt;
   logic          ovr_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state    <= ST_COLLECT;
         fill_cnt <= '0;
         rd_cnt   <= '0;
         ovr_q    <= 1'b0;
      end else begin
         case (state)
            ST_COLLECT: begin
               if (smp_valid) begin
                  fill_cnt <= fill_cnt + 1'b1;
                  if (fill_cnt == LAST) state <= ST_REQUEST;
               end
            end
            ST_REQUEST: begin
               if (smp_valid) ovr_q <= 1'b1;
               if (irq_ack)   state <= ST_DRAIN;
            end
            ST_DRAIN: begin
               if (smp_valid) ovr_q <= 1'b1;
               if (out_ready) begin
                  if (rd_cnt == LAST) begin
                     state    <= ST_COLLECT;
                     rd_cnt   <= '0;
                     fill_cnt <= '0;
                  end else begin
                     rd_cnt <= rd_cnt + 1'b1;
                  end
               end
            end
            default: state <= ST_COLLECT;
         endcase
      end
   end

   assign wr_en     = (state == ST_COLLECT) && smp_valid;
   assign wr_addr   = fill_cnt;
   assign rd_addr   = rd_cnt;
   assign irq_req   = (state == ST_REQUEST);
   assign out_valid = (state == ST_DRAIN);
   assign overrun   = ovr_q;
endmodule

// File: rtl/acq_xfer_ctrl.sv
module acq_xfer_ctrl #(
   parameter int SAMPLE_W = 12,
   parameter int CHAN_W   = 4,
   parameter int TS_W     = 16,
   parameter int DEPTH    = 64,
   localparam int WORD_W  = TS_W + CHAN_W + SAMPLE_W,
   localparam int AW      = $clog2(DEPTH)
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                tick_en,
   input  logic                smp_valid,
   input  logic [SAMPLE_W-1:0] smp_data,
   input  logic [CHAN_W-1:0]   smp_chan,
   output logic                irq_req,
   input  logic                irq_ack,
   output logic                out_valid,
   input  logic                out_ready,
   output logic [WORD_W-1:0]   out_word,
   output logic                overrun
);
   if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
      $error("acq_xfer_ctrl: DEPTH must be a power of two of at least 2");
   end
   if (SAMPLE_W < 1 || CHAN_W < 1 || TS_W < 1) begin : g_bad_width
      $error("acq_xfer_ctrl: field widths must be positive");
   end

   logic [TS_W-1:0]   ts_now;
   logic              wr_en;
   logic [AW-1:0]     wr_addr;
   logic [AW-1:0]     rd_addr;
   logic [WORD_W-1:0] wr_word;

   assign wr_word = {ts_now, smp_chan, smp_data};

   acq_tod_counter #(.TS_W(TS_W)) u_tod (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_en (tick_en),
      .ts_now  (ts_now)
   );

   acq_xfer_seq #(.DEPTH(DEPTH)) u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .smp_valid (smp_valid),
      .irq_ack   (irq_ack),
      .out_ready (out_ready),
      .wr_en     (wr_en),
      .wr_addr   (wr_addr),
      .rd_addr   (rd_addr),
      .irq_req   (irq_req),
      .out_valid (out_valid),
      .overrun   (overrun)
   );

   acq_sample_store #(.WORD_W(WORD_W), .DEPTH(DEPTH)) u_store (
      .clk     (clk),
      .wr_en   (wr_en),
      .wr_addr (wr_addr),
      .wr_word (wr_word),
      .rd_addr (rd_addr),
      .rd_word (out_word)
   );
endmodule

// File: rtl/acq_xfer_chk.sv
module acq_xfer_chk #(
   parameter int TS_W   = 16,
   parameter int WORD_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_en,
   input logic              smp_valid,
   input logic              irq_req,
   input logic              irq_ack,
   input logic              out_valid,
   input logic              out_ready,
   input logic [WORD_W-1:0] out_word,
   input logic              overrun,
   input logic [TS_W-1:0]   ts_now
);
   AST_TS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      tick_en |=> ts_now == TS_W'($past(ts_now) + 1'b1)); // R3
   AST_TS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_en |=> $stable(ts_now)); // R3
   AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && !irq_ack |=> irq_req); // R4
   AST_IRQ_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_req && out_valid)); // R4
   AST_IRQ_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
      irq_req && irq_ack |=> !irq_req && out_valid); // R5
   AST_WORD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid && !out_ready |=> out_valid && $stable(out_word)); // R6
   AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req || out_valid) && smp_valid |=> overrun); // R7
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      overrun |=> overrun); // R7
   AST_ACK_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      !irq_req && !out_valid |=> !out_valid); // R9
endmodule

bind acq_xfer_ctrl acq_xfer_chk #(.TS_W(TS_W), .WORD_W(WORD_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .tick_en   (tick_en),
   .smp_valid (smp_valid),
   .irq_req   (irq_req),
   .irq_ack   (irq_ack),
   .out_valid (out_valid),
   .out_ready (out_ready),
   .out_word  (out_word),
   .overrun   (overrun),
   .ts_now    (ts_now)
);

// File: tb/test_acq_xfer_ctrl.sv
`timescale 1ns/1ps
module test_acq_xfer_ctrl;
   localparam int DEPTH = 64;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_en = 1'b1;
   logic        smp_valid = 1'b0;
   logic [11:0] smp_data = '0;
   logic [3:0]  smp_chan = '0;
   logic        irq_req;
   logic        irq_ack = 1'b0;
   logic        out_valid;
   logic        out_ready = 1'b0;
   logic [31:0] out_word;
   logic        overrun;

   int n_checks = 0;
   int n_errors = 0;
   logic [31:0] exp_q [$];
   logic [15:0] ts_model;
   int cycles = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   acq_xfer_ctrl i_acq_xfer_ctrl (
      .clk(clk), .rst_n(rst_n), .tick_en(tick_en),
      .smp_valid(smp_valid), .smp_data(smp_data), .smp_chan(smp_chan),
      .irq_req(irq_req), .irq_ack(irq_ack),
      .out_valid(out_valid), .out_ready(out_ready), .out_word(out_word),
      .overrun(overrun)
   );

   // independent time-of-day model (R3): +1 per tick-enabled cycle, 16-bit wrap
   always @(posedge clk or negedge rst_n) begin
      if (!rst_n)       ts_model <= '0;
      else if (tick_en) ts_model <= ts_model + 16'd1;
   end

   always @(posedge clk) cycles <= cycles + 1;

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      n_checks++;
      if (!ok) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   // driver: offers one sample; stores expectation only if it should be kept
   task automatic send(input logic [3:0] ch, input logic [11:0] d, input bit keep);
      @(negedge clk);
      smp_valid = 1'b1; smp_chan = ch; smp_data = d;
      if (keep) exp_q.push_back({ts_model, ch, d}); // R2 layout
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   // monitor: pops and compares every accepted word (R2, R6)
   always @(negedge clk) begin
      #2;
      if (rst_n && out_valid && out_ready) begin
         if (exp_q.size() == 0) begin
            chk(1'b0, "R6 extra word", out_word, 32'h0);
         end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            chk(out_word == e, "R2/R6 word", out_word, e);
         end
      end
   end

   task automatic drain(input bit stall);
      for (int i = 0; i < 400; i++) begin
         @(negedge clk);
         out_ready = stall ? ((i % 3) != 2) : 1'b1;
         #3;
         if (!out_valid) break;
      end
      out_ready = 1'b0;
   endtask

   task automatic ack_pulse;
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0;
      #2;
      chk(irq_req == 1'b0, "R5 irq released", irq_req, 0);
      chk(out_valid == 1'b1, "R5 drain started", out_valid, 1);
   endtask

   initial begin
      #2000000;
      if (!done) begin
         chk(1'b0, "watchdog", cycles, 0);
         $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      #2;
      chk(irq_req == 0, "R10 irq", irq_req, 0);
      chk(out_valid == 0, "R10 valid", out_valid, 0);
      chk(overrun == 0, "R10 overrun", overrun, 0);
      rst_n = 1'b1;

      // stray acknowledge while collecting (R9)
      @(negedge clk); irq_ack = 1'b1;
      @(negedge clk); irq_ack = 1'b0; #2;
      chk(out_valid == 0 && irq_req == 0, "R9 ack ignored", {irq_req, out_valid}, 0);

      // batch 1: gaps between samples, tick always on
      for (int i = 0; i < DEPTH - 1; i++) begin
         send(4'(i), 12'(i * 37 + 5), 1'b1);
         if (i % 4 == 1) @(negedge clk);
      end
      #2;
      chk(irq_req == 0, "R1 no irq before full", irq_req, 0);
      send(4'hA, 12'hABC, 1'b1);
      #2;
      chk(irq_req == 1, "R4 irq on full", irq_req, 1);
      chk(out_valid == 0, "R4 no data before ack", out_valid, 0);
      chk(overrun == 0, "R7 overrun clear", overrun, 0);

      // samples while pending are dropped (R7)
      send(4'h3, 12'h111, 1'b0);
      send(4'h4, 12'h222, 1'b0);
      #2;
      chk(overrun == 1, "R7 overrun set", overrun, 1);
      chk(irq_req == 1, "R4 irq held", irq_req, 1);

      ack_pulse();
      drain(1'b1);
      #2;
      chk(exp_q.size() == 0, "R6 all words out", exp_q.size(), 0);
      chk(out_valid == 0 && irq_req == 0, "R8 back to collect", {irq_req, out_valid}, 0);

      // idle long enough to wrap the timestamp (R3)
      repeat (65500) @(negedge clk);

      // batch 2: tick toggles
      for (int i = 0; i < DEPTH - 1; i++) begin
         @(negedge clk); tick_en = (i % 3) != 0;
         send(4'(15 - (i % 16)), 12'(4095 - i * 11), 1'b1);
      end
      tick_en = 1'b1;
      #2;
      chk(irq_req == 0, "R8 needs full batch again", irq_req, 0);
      send(4'h5, 12'h5A5, 1'b1);
      #2;
      chk(irq_req == 1, "R4 irq second batch", irq_req, 1);
      chk(overrun == 1, "R7 overrun sticky", overrun, 1);
      ack_pulse();
      drain(1'b0);
      #2;
      chk(exp_q.size() == 0, "R3/R6 batch two out", exp_q.size(), 0);
      chk(out_valid == 0, "R8 idle after drain", out_valid, 0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule